// File: doc/BRIEF.md
# I2C Slave Address Matcher with Per-Bit Masking

This block is the front end of an I2C slave that decides whether a bus transaction is addressed to it. It oversamples SCL and SDA on the system clock and detects START, repeated START and STOP conditions. It shifts in address bytes and compares each one with a programmable own address. A per-bit mask turns selected bit positions into don't-cares, so one slave can answer a whole set of addresses. When the comparison passes, the block pulls SDA low during the ninth clock to acknowledge. It supports 7-bit addressing and two-byte 10-bit addressing.

A plain configuration port loads the own-address and mask registers through one shared write location. A select code routes each write to one register or the other. The outputs are plain control pins: a one-cycle match strobe, the direction bit of the matched address, and the SDA pull-down enable. No stream data passes through the block, so it has no valid/ready interface. Transfers of data bytes, clock stretching and master operation belong to neighbouring logic.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `sda_pd_o`, `match_o` and `rw_o` are 0, the own address is 0 and the mask is all ones. Until the mask is written, only an exact address match is acknowledged.
- R2: A configuration write with `cfg_sel_i == 4'b1001` loads `cfg_wdata_i[7:0]` into the mask and leaves the own address unchanged. A write with any other select code loads all 10 bits of `cfg_wdata_i` into the own address and leaves the mask unchanged.
- R3: In 7-bit mode (`ten_bit_i = 0`), received byte bits [7:1] are compared with own-address bits [7:1]. A position whose mask bit is 0 is ignored, and a position whose mask bit is 1 must be equal. For example, own A0h with mask F9h acknowledges A0h, A2h, A4h and A6h and rejects A8h.
- R4: In 7-bit mode, bit 0 of the address byte is the R/W flag and is never compared. On a match, `rw_o` takes its value.
- R5: On an acknowledged address, `sda_pd_o` rises after the falling SCL edge that ends the eighth bit. It stays high while SCL is high during the ninth clock and is released after the ninth falling edge. `match_o` pulses for exactly one cycle for each complete address match.
- R6: On a mismatch, SDA is not driven on the ninth clock. After that, the block ignores all SCL activity until the next START, even if a later byte would match.
- R7: In 10-bit mode, the first byte is 11110 followed by A9, A8 and R/W=0. It is acknowledged when A9:A8 equal own-address bits [9:8]. The following byte is acknowledged, with a match strobe and `rw_o = 0`, when it passes the masked comparison against own-address bits [7:0].
- R8: A9:A8 are never masked. A header with different A9:A8 is rejected even when the mask is all zeros.
- R9: In 10-bit mode, all eight mask bits act on the low address byte, bit 0 included. A mask of 00h therefore accepts any low byte.
- R10: After a 10-bit low-byte match, a repeated START followed by the header with R/W=1 is acknowledged and strobed with `rw_o = 1`. A STOP cancels this state, and a read header with no valid earlier match is rejected.
- R11: A START or STOP in the middle of an address byte aborts it and clears the bit count. A following complete address is then received from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 4 | Register select; 4'b1001 routes the write to the mask |
| cfg_wdata_i | input | 10 | Configuration write data |
| sda_pd_o | output | 1 | Drive SDA low (acknowledge) |
| match_o | output | 1 | One-cycle strobe on a complete address match |
| rw_o | output | 1 | R/W bit of the most recently matched address |

## Verification
A wrong bit count or shift register shows up on the ninth clock of the same byte: the acknowledge appears on the wrong clock or is missing. Wrong mask or own-address contents show up as an acknowledge on a rejected address, or a missing one on an accepted address, in the first transaction after the register write. A 10-bit read state that survives a STOP shows up only at the next read header, so the bench follows a STOP directly with such a header. The bench also sends bytes after a rejected address to show that an ignore state which ends too early is visible.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_ACK    = 2'd2,
    ST_IGNORE = 2'd3
  } am_state_e;

  // fixed prefix of the first byte of a 10-bit address
  localparam logic [4:0] TEN_HDR = 5'b11110;
endpackage

// File: rtl/i2c_am_sense.sv
module i2c_am_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_level,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_level = scl_pipe[SYNC_STAGES-1];
  assign sda_bit   = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_level;
      sda_q <= sda_bit;
    end
  end

  assign scl_rise  = scl_level & ~scl_q;
  assign scl_fall  = ~scl_level & scl_q;
  assign start_det = scl_level & scl_q & sda_q & ~sda_bit;
  assign stop_det  = scl_level & scl_q & ~sda_q & sda_bit;
endmodule

// File: rtl/i2c_am_regs.sv
module i2c_am_regs #(
  parameter int AW = 10,
  parameter int LW = 8,
  parameter int SW = 4,
  parameter logic [SW-1:0] MASK_SEL = 4'b1001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] own,
  output logic [LW-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own  <= '0;
      mask <= '1;
    end else if (we) begin
      if (sel == MASK_SEL) mask <= wdata[LW-1:0];
      else                 own  <= wdata;
    end
  end
endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
  import i2c_am_pkg::*;
#(
  parameter int AW = 10,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_bit,
  input  logic          ten_bit,
  input  logic [AW-1:0] own,
  input  logic [LW-1:0] mask,
  output logic          sda_pd,
  output logic          match_stb,
  output logic          rw,
  output logic          ignoring,
  output logic [3:0]    bit_cnt
);
  localparam int HI_W = AW - LW;
  localparam logic [3:0] LAST_BIT = 4'(LW - 1);
  localparam logic [3:0] ACK_SLOT = 4'(LW);

  am_state_e      st;
  logic [LW-1:0]  shreg, byte_in;
  logic           second, hi_ok;
  logic           ack_p, full_p, rw_p, low_p;
  logic           m7, hdr_ok, lo_ok;
  logic           d_ack, d_full, d_rw, d_low;

  assign byte_in = {shreg[LW-2:0], sda_bit};
  assign m7      = (((byte_in[LW-1:1] ^ own[LW-1:1]) & mask[LW-1:1]) == '0);
  assign hdr_ok  = (byte_in[LW-1:3] == TEN_HDR) && (byte_in[2:1] == own[AW-1:AW-HI_W]);
  assign lo_ok   = (((byte_in ^ own[LW-1:0]) & mask) == '0);

  always_comb begin
    d_ack  = 1'b0;
    d_full = 1'b0;
    d_rw   = byte_in[0];
    d_low  = 1'b0;
    if (!ten_bit) begin
      d_ack  = m7;
      d_full = m7;
    end else if (!second) begin
      if (hdr_ok && !byte_in[0]) begin
        d_ack = 1'b1;
        d_low = 1'b1;
      end else if (hdr_ok && hi_ok) begin
        d_ack  = 1'b1;
        d_full = 1'b1;
      end
    end else begin
      d_ack  = lo_ok;
      d_full = lo_ok;
      d_rw   = 1'b0;
    end
  end

  assign ignoring = (st == ST_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      shreg     <= '0;
      bit_cnt   <= '0;
      second    <= 1'b0;
      hi_ok     <= 1'b0;
      ack_p     <= 1'b0;
      full_p    <= 1'b0;
      rw_p      <= 1'b0;
      low_p     <= 1'b0;
      sda_pd    <= 1'b0;
      match_stb <= 1'b0;
      rw        <= 1'b0;
    end else begin
      match_stb <= 1'b0;
      if (start_det) begin
        st      <= ST_ADDR;
        bit_cnt <= '0;
        second  <= 1'b0;
        sda_pd  <= 1'b0;
      end else if (stop_det) begin
        st      <= ST_IDLE;
        bit_cnt <= '0;
        second  <= 1'b0;
        sda_pd  <= 1'b0;
        hi_ok   <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= byte_in;
              if (bit_cnt == LAST_BIT) begin
                ack_p   <= d_ack;
                full_p  <= d_full;
                rw_p    <= d_rw;
                low_p   <= d_low;
                bit_cnt <= ACK_SLOT;
                // a new 10-bit write header voids any earlier read permission
                if (ten_bit && !second && !byte_in[0]) hi_ok <= 1'b0;
                if (ten_bit && second && lo_ok)        hi_ok <= 1'b1;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
              end
            end else if (scl_fall && bit_cnt == ACK_SLOT) begin
              st        <= ST_ACK;
              sda_pd    <= ack_p;
              match_stb <= full_p;
              if (full_p) rw <= rw_p;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_pd  <= 1'b0;
              bit_cnt <= '0;
              if (ack_p && low_p) begin
                st     <= ST_ADDR;
                second <= 1'b1;
              end else begin
                st <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 10,
  parameter int LOW_W = 8,
  parameter int SEL_W = 4,
  parameter logic [SEL_W-1:0] MASK_SEL = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             ten_bit_i,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic             sda_pd_o,
  output logic             match_o,
  output logic             rw_o
);
  logic scl_level, sda_bit, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own;
  logic [LOW_W-1:0]  mask;
  logic              ignoring;
  logic [3:0]        bit_cnt;

  i2c_am_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_level(scl_level), .sda_bit(sda_bit), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_am_regs #(.AW(ADDR_W), .LW(LOW_W), .SW(SEL_W), .MASK_SEL(MASK_SEL)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .sel(cfg_sel_i),
    .wdata(cfg_wdata_i), .own(own), .mask(mask)
  );

  i2c_am_fsm #(.AW(ADDR_W), .LW(LOW_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
    .ten_bit(ten_bit_i), .own(own), .mask(mask), .sda_pd(sda_pd_o),
    .match_stb(match_o), .rw(rw_o), .ignoring(ignoring), .bit_cnt(bit_cnt)
  );
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk #(
  parameter int SEL_W = 4,
  parameter int LOW_W = 8,
  parameter logic [SEL_W-1:0] MASK_SEL = 4'b1001
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_level,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_pd_o,
  input logic             match_o,
  input logic             cfg_we_i,
  input logic [SEL_W-1:0] cfg_sel_i,
  input logic [LOW_W-1:0] mask,
  input logic             ignoring,
  input logic [3:0]       bit_cnt
);
  assert_pd_rise_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd_o) |-> $past(scl_fall));

  assert_pd_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pd_o) |-> $past(scl_fall || start_det || stop_det));

  assert_pd_steady_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_level && $past(scl_level) && !$past(start_det || stop_det)) |-> $stable(sda_pd_o));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  assert_strobe_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> sda_pd_o);

  assert_ignore_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_pd_o);

  assert_own_write_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_sel_i != MASK_SEL) |=> $stable(mask));

  assert_cond_clears_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (bit_cnt == 4'd0));
endmodule

bind i2c_addr_match i2c_am_chk #(.SEL_W(SEL_W), .LOW_W(LOW_W), .MASK_SEL(MASK_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_level(scl_level), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .sda_pd_o(sda_pd_o),
  .match_o(match_o), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
  .mask(mask), .ignoring(ignoring), .bit_cnt(bit_cnt)
);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
  localparam int CLK_P = 10;
  localparam int Q = 8;
  localparam int NV = 16;
  localparam logic [3:0] SEL_MASK = 4'b1001;

  // {ten, own[9:0], mask[7:0], two, b0, b1, ack0, ack1, strobe, rw}
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 10'h0A0, 8'hFF, 1'b0, 8'hA0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 10'h0A0, 8'hF9, 1'b0, 8'hA2, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 10'h0A0, 8'hF9, 1'b0, 8'hA6, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 10'h0A0, 8'hF9, 1'b0, 8'hA4, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 10'h0A0, 8'hF9, 1'b0, 8'hA8, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'h0A0, 8'hF9, 1'b0, 8'hA5, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {1'b0, 10'h0A0, 8'hFF, 1'b0, 8'hA1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {1'b0, 10'h0A0, 8'hFF, 1'b0, 8'hB0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h2A5, 8'hFF, 1'b1, 8'hF4, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 10'h2A5, 8'hFF, 1'b1, 8'hF4, 8'hA4, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h2A5, 8'h00, 1'b1, 8'hF6, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h2A5, 8'h00, 1'b1, 8'hF4, 8'h13, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 10'h2A5, 8'hF0, 1'b1, 8'hF4, 8'hA3, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 10'h2A5, 8'hF0, 1'b1, 8'hF4, 8'hB5, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h2A5, 8'hFF, 1'b0, 8'hF5, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h1A5, 8'hFF, 1'b1, 8'hF2, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ten_bit = 1'b0, cfg_we = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic [9:0] cfg_wdata = '0;
  logic sda_pd, match, rw;
  logic sda_line;
  int checks = 0, errors = 0, stb_cnt = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_pd;

  always #(CLK_P/2) clk = ~clk;

  i2c_addr_match u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .ten_bit_i(ten_bit), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .sda_pd_o(sda_pd), .match_o(match), .rw_o(rw)
  );

  always @(posedge clk) if (rst_n && match) stb_cnt <= stb_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic cfg(input logic [3:0] sel, input logic [9:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
  endtask

  // sends a byte, returns the level of the pull-down in the 9th clock and after it
  task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = sda_pd;
    wq(); scl_m = 1'b0; wq();
    rel = sda_pd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a, r;
    int s0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pd after reset", sda_pd, 0);
    chk("R1 match after reset", match, 0);
    chk("R1 rw after reset", rw, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 mask all ones: only exact address acknowledged
    cfg(4'b0000, 10'h0A0);
    bus_start(); send_byte(8'hA2, a, r); bus_stop();
    chk("R1 default mask rejects A2", a, 0);
    bus_start(); send_byte(8'hA0, a, r); bus_stop();
    chk("R1 default mask accepts A0", a, 1);

    // R2 non-mask select loads own address, mask stays all ones
    cfg(4'b0110, 10'h0A2);
    bus_start(); send_byte(8'hA2, a, r); bus_stop();
    chk("R2 own written via other select", a, 1);
    bus_start(); send_byte(8'hA0, a, r); bus_stop();
    chk("R2 mask untouched by own write", a, 0);

    // table walk: R3 R4 R5 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      logic a0, a1, r0, r1;
      ten_bit = VEC[v][39];
      cfg(4'b0000, VEC[v][38:29]);
      cfg(SEL_MASK, {2'b00, VEC[v][28:21]});
      s0 = stb_cnt;
      a1 = 1'b0; r1 = 1'b0;
      bus_start();
      send_byte(VEC[v][19:12], a0, r0);
      if (VEC[v][20]) send_byte(VEC[v][11:4], a1, r1);
      bus_stop();
      chk($sformatf("R3/R7/R8/R9 vec%0d first ack", v), a0, VEC[v][3]);
      if (VEC[v][20]) chk($sformatf("R7/R9 vec%0d second ack", v), a1, VEC[v][2]);
      chk($sformatf("R5 vec%0d release after 9th", v), r0 | r1, 0);
      chk($sformatf("R5 vec%0d strobes", v), stb_cnt - s0, VEC[v][1]);
      if (VEC[v][1]) chk($sformatf("R4 vec%0d rw", v), rw, VEC[v][0]);
    end

    // R6 ignore until START after mismatch
    ten_bit = 1'b0;
    cfg(4'b0000, 10'h0A0);
    cfg(SEL_MASK, 10'h0FF);
    bus_start();
    send_byte(8'hA8, a, r);
    chk("R6 mismatch not acked", a, 0);
    send_byte(8'hA0, a, r);
    chk("R6 matching byte ignored without START", a, 0);
    bus_stop();

    // R11 START in the middle of a byte
    bus_start(); send_bits(8'hA0, 4); bus_start();
    send_byte(8'hA0, a, r); bus_stop();
    chk("R11 restart mid-byte then full address", a, 1);
    // R11 STOP in the middle of a byte
    bus_start(); send_bits(8'hA0, 5); bus_stop();
    bus_start(); send_byte(8'hA0, a, r); bus_stop();
    chk("R11 stop mid-byte then full address", a, 1);

    // R10 10-bit read via repeated START
    ten_bit = 1'b1;
    cfg(4'b0000, 10'h2A5);
    s0 = stb_cnt;
    bus_start();
    send_byte(8'hF4, a, r); chk("R7 header ack", a, 1);
    send_byte(8'hA5, a, r); chk("R7 low byte ack", a, 1);
    chk("R7 rw after write match", rw, 0);
    bus_start();
    send_byte(8'hF5, a, r); chk("R10 read header after restart", a, 1);
    bus_stop();
    chk("R10 rw after read match", rw, 1);
    chk("R10 strobe count", stb_cnt - s0, 2);
    bus_start(); send_byte(8'hF5, a, r); bus_stop();
    chk("R10 STOP cancels read permission", a, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule